// File: doc/BRIEF.md
# Peripheral Clock Gating and Sleep Sequencer

This block controls the clocks of a bank of up to 160 peripherals and brings the system into a low-power sleep state. Each peripheral has one sleep-enable bit, written over a simple register bus, and one clock-request input that the peripheral drives itself. A peripheral's clock is stopped only when software has allowed it and the peripheral has said it no longer needs it. A request from a peripheral always keeps its clock running.

A control register chooses between a light and a heavy sleep. A second bit must be set before any sleep entry happens at all. A third bit lets heavy sleep start before the PLL has locked. When the processor raises its sleep signal, a small sequencer waits until every clock request in the bank is low and entry is allowed. It then asserts either the light or the heavy sleep output. A wake pulse returns the sequencer to the running state. A status register reports the PLL lock input. The bank of request inputs can be read back over the bus.

The bus is synchronous. A cycle with valid high and write high stores data. A cycle with valid high and write low loads read data, which appears on the output after the next clock edge.

Top module: `clkgate_sleep_ctrl`

## Requirements
- R1: After reset every register reads zero, every peripheral clock enable is 1, and both sleep outputs are 0.
- R2: `periph_clk_en[i]` is 0 exactly when sleep-enable bit i is 1 and `clk_req[i]` is 0. It follows `clk_req` in the same cycle and follows a register write from the edge that stores it.
- R3: Sleep-enable bank b (0 to 4) sits at byte address 0x30+4*b and holds bits 32*b+31..32*b. A written value reads back unchanged.
- R4: Request bank b reads `clk_req[32*b+31:32*b]` at byte address 0x50+4*b. A write to these addresses changes no register.
- R5: The control register at 0x00 keeps only the bits in mask 0x109. Bit 0 selects heavy (1) or light (0) sleep. Bit 3 is the sleep-all flag. Bit 8 allows heavy sleep without PLL lock.
- R6: The status register at 0x0C reads `pll_locked` in bit 8 and zero elsewhere. Writes to it are ignored.
- R7: `cpu_sleep` with the sleep-all flag set moves the sequencer from running to waiting at the next edge. With the flag clear, the sequencer stays running and no sleep output rises.
- R8: While waiting, at the first edge where all 160 requests are low and entry is allowed, the sequencer enters heavy sleep if bit 0 is 1 and light sleep otherwise. The matching output is high from that edge on.
- R9: Entry is allowed when `pll_locked` is 1, or when bits 8 and 0 are both 1. Light sleep is never entered while the PLL is unlocked.
- R10: `wake` in the waiting or a sleep state, or `cpu_sleep` low while waiting, returns the sequencer to running at the next edge.
- R11: `sleep_light` and `sleep_heavy` are never high together.
- R12: A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge that took the read |
| clk_req | input | 160 | Per-peripheral clock request |
| cpu_sleep | input | 1 | Processor sleep request |
| wake | input | 1 | Wake event |
| pll_locked | input | 1 | PLL lock indication |
| periph_clk_en | output | 160 | Per-peripheral clock enable |
| sleep_light | output | 1 | Light sleep active |
| sleep_heavy | output | 1 | Heavy sleep active |

## Verification
The clock enables have no register between them and the request inputs. They must therefore match the expected value in the same cycle that `clk_req` changes, and in the cycle after a sleep-enable write is stored. Read data and both sleep outputs come from registers. Each is due one edge after the access or the sequencer condition that causes it. A sleep output therefore rises two edges after `cpu_sleep` when the requests are already clear. The reference model advances on every rising edge from the same inputs the design sees. All outputs are compared on the falling edge, and inputs are changed only just after that comparison, so each check samples a settled value.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_WAIT_REQ    = 2'd1,
    ST_SLEEP_LIGHT = 2'd2,
    ST_SLEEP_HEAVY = 2'd3
  } seq_state_e;

  localparam int CTRL_HEAVY_BIT  = 0;
  localparam int CTRL_ALL_BIT    = 3;
  localparam int CTRL_NOLOCK_BIT = 8;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_0109;
  localparam int STAT_LOCK_BIT   = 8;

endpackage

// File: rtl/cgs_regfile.sv
module cgs_regfile
  import cgs_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int CTRL_OFS  = 'h00,
  parameter int STAT_OFS  = 'h0C,
  parameter int EN_BASE   = 'h30,
  parameter int REQ_BASE  = 'h50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  input  logic [NUM_BANKS*BANK_W-1:0] clk_req,
  input  logic                        pll_locked,
  output logic [NUM_BANKS*BANK_W-1:0] slp_en,
  output logic                        ctrl_heavy,
  output logic                        ctrl_all,
  output logic                        ctrl_nolock,
  output logic [BANK_W-1:0]           bus_rdata
);

  localparam int NBITS  = NUM_BANKS * BANK_W;
  localparam int STRIDE = BANK_W / 8;

  logic [NBITS-1:0]  en_q, en_d;
  logic [BANK_W-1:0] ctrl_q, ctrl_d;
  logic [BANK_W-1:0] rd_q, rd_d;
  logic              wr_cyc, rd_cyc, hit_req_any;

  assign wr_cyc = bus_valid &  bus_write;
  assign rd_cyc = bus_valid & ~bus_write;

  // next-state for the writable registers and the read mux
  always_comb begin
    en_d        = en_q;
    ctrl_d      = ctrl_q;
    rd_d        = '0;
    hit_req_any = 1'b0;
    if (wr_cyc && bus_addr == ADDR_W'(CTRL_OFS))
      ctrl_d = bus_wdata & CTRL_WMASK[BANK_W-1:0];
    if (bus_addr == ADDR_W'(CTRL_OFS)) rd_d = ctrl_q;
    if (bus_addr == ADDR_W'(STAT_OFS)) rd_d[STAT_LOCK_BIT] = pll_locked;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(EN_BASE + STRIDE*b)) begin
        rd_d = en_q[b*BANK_W +: BANK_W];
        if (wr_cyc) en_d[b*BANK_W +: BANK_W] = bus_wdata;
      end
      if (bus_addr == ADDR_W'(REQ_BASE + STRIDE*b)) begin
        rd_d        = clk_req[b*BANK_W +: BANK_W];
        hit_req_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ctrl_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_cyc) begin
        en_q   <= en_d;
        ctrl_q <= ctrl_d;
      end
      if (rd_cyc) rd_q <= rd_d;
    end
  end

  assign slp_en      = en_q;
  assign ctrl_heavy  = ctrl_q[CTRL_HEAVY_BIT];
  assign ctrl_all    = ctrl_q[CTRL_ALL_BIT];
  assign ctrl_nolock = ctrl_q[CTRL_NOLOCK_BIT];
  assign bus_rdata   = rd_q;

  a_r4_req_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && hit_req_any) |=> $stable(en_q) && $stable(ctrl_q));

  a_r6_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && bus_addr == ADDR_W'(STAT_OFS)) |=>
      ($countones(bus_rdata) == 32'($past(pll_locked))) &&
      (bus_rdata[STAT_LOCK_BIT] == $past(pll_locked)));

endmodule

// File: rtl/cgs_gate.sv
module cgs_gate #(
  parameter int NBITS = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] slp_en,
  input  logic [NBITS-1:0] clk_req,
  output logic [NBITS-1:0] clk_en,
  output logic             req_any
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign clk_en[i] = ~slp_en[i] | clk_req[i];
  end

  assign req_any = |clk_req;

  a_r2_request_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req & ~clk_en) == '0);

endmodule

// File: rtl/cgs_seq.sv
module cgs_seq
  import cgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_sleep,
  input  logic wake,
  input  logic pll_locked,
  input  logic req_any,
  input  logic sleep_all,
  input  logic heavy_sel,
  input  logic nolock_ok,
  output logic sleep_light,
  output logic sleep_heavy
);

  seq_state_e state_q, state_d;
  logic       entry_ok;

  assign entry_ok = pll_locked | (nolock_ok & heavy_sel);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:
        if (cpu_sleep && sleep_all) state_d = ST_WAIT_REQ;
      ST_WAIT_REQ:
        if (wake || !cpu_sleep)        state_d = ST_RUN;
        else if (!req_any && entry_ok) state_d = heavy_sel ? ST_SLEEP_HEAVY : ST_SLEEP_LIGHT;
      ST_SLEEP_LIGHT, ST_SLEEP_HEAVY:
        if (wake) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign sleep_light = (state_q == ST_SLEEP_LIGHT);
  assign sleep_heavy = (state_q == ST_SLEEP_HEAVY);

  a_r7_no_flag_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !sleep_all) |=> state_q == ST_RUN);

  a_r8_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sleep_light) || $rose(sleep_heavy)) |-> $past(!req_any && cpu_sleep));

  a_r9_light_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_light) |-> $past(pll_locked));

  a_r10_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && wake) |=> state_q == ST_RUN);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_light, sleep_heavy}));

endmodule

// File: rtl/clkgate_sleep_ctrl.sv
module clkgate_sleep_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int CTRL_OFS  = 'h00,
  parameter int STAT_OFS  = 'h0C,
  parameter int EN_BASE   = 'h30,
  parameter int REQ_BASE  = 'h50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] clk_req,
  input  logic                        cpu_sleep,
  input  logic                        wake,
  input  logic                        pll_locked,
  output logic [NUM_BANKS*BANK_W-1:0] periph_clk_en,
  output logic                        sleep_light,
  output logic                        sleep_heavy
);

  localparam int NBITS = NUM_BANKS * BANK_W;

  logic [NBITS-1:0] slp_en;
  logic             ctrl_heavy, ctrl_all, ctrl_nolock, req_any;

  cgs_regfile #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .EN_BASE(EN_BASE), .REQ_BASE(REQ_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .clk_req(clk_req), .pll_locked(pll_locked),
    .slp_en(slp_en), .ctrl_heavy(ctrl_heavy), .ctrl_all(ctrl_all),
    .ctrl_nolock(ctrl_nolock), .bus_rdata(bus_rdata)
  );

  cgs_gate #(.NBITS(NBITS)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .slp_en(slp_en), .clk_req(clk_req),
    .clk_en(periph_clk_en), .req_any(req_any)
  );

  cgs_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_sleep(cpu_sleep), .wake(wake), .pll_locked(pll_locked),
    .req_any(req_any), .sleep_all(ctrl_all), .heavy_sel(ctrl_heavy),
    .nolock_ok(ctrl_nolock),
    .sleep_light(sleep_light), .sleep_heavy(sleep_heavy)
  );

endmodule

// File: tb/clkgate_sleep_ctrl_test.sv
module clkgate_sleep_ctrl_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [159:0] clk_req = '0;
  logic         cpu_sleep = 1'b0, wake = 1'b0, pll_locked = 1'b0;
  logic [159:0] periph_clk_en;
  logic         sleep_light, sleep_heavy;

  int n_chk = 0, n_err = 0;
  bit started = 0;

  always #2 clk = ~clk;

  clkgate_sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_req(clk_req), .cpu_sleep(cpu_sleep), .wake(wake),
    .pll_locked(pll_locked), .periph_clk_en(periph_clk_en),
    .sleep_light(sleep_light), .sleep_heavy(sleep_heavy)
  );

  task automatic check(string tag, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_en [5];
  logic [31:0] m_ctrl, m_rd;
  int          m_state;   // 0 run, 1 waiting, 2 light, 3 heavy

  function automatic logic [31:0] m_read(logic [7:0] a);
    for (int b = 0; b < 5; b++) begin
      if (a == 8'(8'h30 + 4*b)) return m_en[b];
      if (a == 8'(8'h50 + 4*b)) return clk_req[32*b +: 32];
    end
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h0C) return {23'd0, pll_locked, 8'd0};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 5; b++) m_en[b] = '0;
      m_ctrl = '0; m_rd = '0; m_state = 0;
    end else begin
      int nxt;
      bit ok;
      nxt = m_state;
      ok  = pll_locked || (m_ctrl[8] && m_ctrl[0]);
      case (m_state)
        0: if (cpu_sleep && m_ctrl[3]) nxt = 1;
        1: if (wake || !cpu_sleep) nxt = 0;
           else if (clk_req == '0 && ok) nxt = m_ctrl[0] ? 3 : 2;
        default: if (wake) nxt = 0;
      endcase
      if (bus_valid && !bus_write) m_rd = m_read(bus_addr);
      if (bus_valid && bus_write) begin
        for (int b = 0; b < 5; b++)
          if (bus_addr == 8'(8'h30 + 4*b)) m_en[b] = bus_wdata;
        if (bus_addr == 8'h00) m_ctrl = bus_wdata & 32'h109;
      end
      m_state = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      logic [159:0] exp_en;
      for (int b = 0; b < 5; b++)
        exp_en[32*b +: 32] = ~(m_en[b] & ~clk_req[32*b +: 32]);
      check("R2 clk_en", periph_clk_en, exp_en);
      check("R8 sleep_light", 160'(sleep_light), 160'(m_state == 2));
      check("R8 sleep_heavy", 160'(sleep_heavy), 160'(m_state == 3));
      check("R11 exclusive", 160'(sleep_light & sleep_heavy), 160'd0);
      check("R3 rdata", 160'(bus_rdata), 160'(m_rd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_op(bit w, logic [7:0] a, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk); rd = bus_rdata; #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    logic [31:0] unused_rd;
    bus_op(1'b1, a, d, unused_rd);
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_op(1'b0, a, 32'd0, v);
    check(tag, 160'(v), 160'(exp));
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 clk_en all on", periph_clk_en, {160{1'b1}});
    check("R1 sleep outputs", 160'({sleep_light, sleep_heavy}), 160'd0);
    check("R1 rdata", 160'(bus_rdata), 160'd0);
    rd_chk("R1 ctrl reset", 8'h00, 32'd0);
    rd_chk("R1 enable reset", 8'h3C, 32'd0);

    // R3 enable registers
    wr(8'h30, 32'hA5A5_0F0F);
    rd_chk("R3 bank0 readback", 8'h30, 32'hA5A5_0F0F);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R3 bank4 readback", 8'h40, 32'hFFFF_FFFF);

    // R2 gating rule
    check("R2 bank0 no req", 160'(periph_clk_en[31:0]), 160'(32'h5A5A_F0F0));
    clk_req[31:0] = 32'hFFFF_0000;
    #1 check("R2 bank0 with req", 160'(periph_clk_en[31:0]), 160'(32'hFFFF_F0F0));
    clk_req[159:128] = 32'h0000_00FF;
    #1 check("R2 bank4 with req", 160'(periph_clk_en[159:128]), 160'(32'h0000_00FF));
    clk_req = '0;

    // R4 request registers read-only
    clk_req[95:64] = 32'h1234_5678;
    rd_chk("R4 req bank2 read", 8'h58, 32'h1234_5678);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk("R4 req write ignored", 8'h58, 32'h1234_5678);
    rd_chk("R4 enable bank2 untouched", 8'h38, 32'd0);
    clk_req = '0;

    // R12 unmapped
    rd_chk("R12 unmapped 0x20", 8'h20, 32'd0);
    rd_chk("R12 unmapped 0x44", 8'h44, 32'd0);

    // R5 control mask
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R5 ctrl mask", 8'h00, 32'h0000_0109);

    // R6 status
    pll_locked = 1'b1;
    rd_chk("R6 status locked", 8'h0C, 32'h0000_0100);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R6 status write ignored", 8'h0C, 32'h0000_0100);
    pll_locked = 1'b0;
    rd_chk("R6 status unlocked", 8'h0C, 32'd0);

    // R7 sleep-all clear: no sleep
    pll_locked = 1'b1;
    wr(8'h00, 32'h0000_0001);
    cpu_sleep = 1'b1;
    cycles(5);
    check("R7 no sleep without flag", 160'({sleep_light, sleep_heavy}), 160'd0);
    cpu_sleep = 1'b0;

    // R8 light entry waits for requests
    wr(8'h00, 32'h0000_0008);
    clk_req[101] = 1'b1;
    cpu_sleep = 1'b1;
    cycles(5);
    check("R8 waits on request", 160'(sleep_light), 160'd0);
    clk_req = '0;
    cycles(1);
    check("R8 light entered", 160'({sleep_light, sleep_heavy}), 160'b10);
    // R10 wake
    wake = 1'b1; cpu_sleep = 1'b0;
    cycles(1);
    check("R10 wake from light", 160'(sleep_light), 160'd0);
    wake = 1'b0;

    // R9 no entry unlocked, then heavy allowed by bit 8
    pll_locked = 1'b0;
    cpu_sleep = 1'b1;
    cycles(5);
    check("R9 light blocked unlocked", 160'(sleep_light), 160'd0);
    wr(8'h00, 32'h0000_0109);
    cycles(1);
    check("R9 heavy without lock", 160'(sleep_heavy), 160'd1);
    wake = 1'b1; cpu_sleep = 1'b0;
    cycles(1);
    check("R10 wake from heavy", 160'(sleep_heavy), 160'd0);
    wake = 1'b0;

    // R9 heavy without bit 8 waits for lock
    wr(8'h00, 32'h0000_0009);
    cpu_sleep = 1'b1;
    cycles(4);
    check("R9 heavy waits for lock", 160'(sleep_heavy), 160'd0);
    pll_locked = 1'b1;
    cycles(1);
    check("R8 heavy entered on lock", 160'(sleep_heavy), 160'd1);
    wake = 1'b1; cpu_sleep = 1'b0;
    cycles(1);
    wake = 1'b0;

    // R10 dropping cpu_sleep while waiting aborts
    clk_req[7] = 1'b1;
    cpu_sleep = 1'b1;
    cycles(2);
    cpu_sleep = 1'b0;
    cycles(1);
    clk_req = '0;
    cycles(4);
    check("R10 abort wait returns to run", 160'({sleep_light, sleep_heavy}), 160'd0);

    // R10 wake while waiting
    clk_req[7] = 1'b1;
    cpu_sleep = 1'b1;
    cycles(2);
    wake = 1'b1;
    cycles(1);
    wake = 1'b0; cpu_sleep = 1'b0; clk_req = '0;
    cycles(3);
    check("R10 wake in wait", 160'({sleep_light, sleep_heavy}), 160'd0);

    cycles(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule